// File: doc/BRIEF.md
# Power-Up Recall Supervisor

This block decides when a shadowed memory must refill its working array from the nonvolatile copy, and when a nonvolatile save may go ahead. It watches two digital supply flags. One says the supply is under the reset threshold. The other says it is under the higher switch threshold. Leaving reset, or any dip deep enough to raise the reset flag, latches a pending recall. The recall starts once both flags clear.

When the recall starts, the block emits a one-cycle start pulse. It then holds a busy line, which also tells the data pins to float, for a parameterised number of clock cycles that stands for the restore time. A ready line rises when that window ends. A shallow brown-out only blocks save requests and leaves no recall behind, because the switch flag rises without the reset flag. Save requests pass through only while the supply is good and no restore is running.

Top module: `recall_supervisor`

## Requirements
- R1: After reset a recall is pending. While either supply flag is high, no start pulse is issued, busy_o stays 0 and ready_o stays 0.
- R2: With a recall pending, the first clock edge that samples both supply flags at 0 raises recall_start_o for exactly one cycle and clears the pending request.
- R3: busy_o and out_hiz_o rise together with recall_start_o and stay high for exactly RESTORE_CYCLES clock cycles.
- R4: ready_o is 1 exactly when no restore is running, no recall is pending and both supply flags are 0.
- R5: A dip that raises vcc_lt_switch_i alone (vcc_lt_reset_i = 0) latches no request, and recovery from it starts no recall.
- R6: Any cycle with vcc_lt_reset_i = 1 latches a request. The recall waits until both flags are back at 0, so it does not start while vcc_lt_switch_i is still 1.
- R7: Several deep dips before recovery merge into one request, which produces one recall.
- R8: store_en_o equals store_req_i when both flags are 0 and busy_o is 0; otherwise store_en_o is 0.
- R9: The invalid flag pair vcc_lt_reset_i = 1 with vcc_lt_switch_i = 0 counts as a supply below both levels. It blocks saves and latches a recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; stands for power-up |
| vcc_lt_reset_i | input | 1 | 1 when the supply is below the reset level |
| vcc_lt_switch_i | input | 1 | 1 when the supply is below the switch level |
| store_req_i | input | 1 | Nonvolatile save request from the sequence decoder |
| store_en_o | output | 1 | Gated save enable |
| recall_start_o | output | 1 | One-cycle pulse when an automatic recall begins |
| busy_o | output | 1 | High for the restore window |
| out_hiz_o | output | 1 | Data pins float while high (during the restore) |
| ready_o | output | 1 | Array usable: no restore running or pending, supply good |

## Verification
The bench builds the block with RESTORE_CYCLES = 8, not the default that stands for the full restore time. A short window lets the bench count the whole busy period cycle by cycle in every scenario. With that window, back-to-back scenarios can run power-up, shallow brown-out, deep dip, merged dips, the invalid flag pair and save gating during a restore, all in a few hundred cycles. The checker measures the busy length with its own counter, so that measurement does not depend on the parameter value.

// File: rtl/recall_supervisor.sv
module recall_supervisor #(
  parameter int RESTORE_CYCLES = 55000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_lt_reset_i,
  input  logic vcc_lt_switch_i,
  input  logic store_req_i,
  output logic store_en_o,
  output logic recall_start_o,
  output logic busy_o,
  output logic out_hiz_o,
  output logic ready_o
);
  localparam int CW = $clog2(RESTORE_CYCLES + 1);

  logic          req_q, busy_q, start_q;
  logic [CW-1:0] cnt_q;
  logic          supply_low, deep_dip, launch;

  assign deep_dip   = vcc_lt_reset_i;
  assign supply_low = vcc_lt_switch_i | vcc_lt_reset_i;
  assign launch     = req_q & ~busy_q & ~supply_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b1;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= launch;
      if (deep_dip)    req_q <= 1'b1;
      else if (launch) req_q <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(RESTORE_CYCLES);
      end else if (busy_q) begin
        if (cnt_q == CW'(1)) busy_q <= 1'b0;
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign recall_start_o = start_q;
  assign busy_o         = busy_q;
  assign out_hiz_o      = busy_q;
  assign ready_o        = ~busy_q & ~req_q & ~supply_low;
  assign store_en_o     = store_req_i & ~supply_low & ~busy_q;
endmodule

// File: rtl/recall_supervisor_chk.sv
module recall_supervisor_chk #(
  parameter int RESTORE_CYCLES = 55000
) (
  input logic clk,
  input logic rst_n,
  input logic vcc_lt_reset_i,
  input logic vcc_lt_switch_i,
  input logic store_en_o,
  input logic recall_start_o,
  input logic busy_o,
  input logic out_hiz_o,
  input logic req
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= 0;
    else if (busy_o) run <= run + 1;
    else             run <= 0;
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start_o |=> !recall_start_o);
  assert_start_needs_good_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start_o |-> $past(!vcc_lt_reset_i && !vcc_lt_switch_i));
  assert_start_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (recall_start_o && out_hiz_o));
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run == RESTORE_CYCLES));
  assert_no_store_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !store_en_o);
  assert_no_store_low_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_lt_reset_i || vcc_lt_switch_i) |-> !store_en_o);
  assert_shallow_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !vcc_lt_reset_i) |=> !req);
endmodule

bind recall_supervisor recall_supervisor_chk #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_lt_reset_i(vcc_lt_reset_i),
  .vcc_lt_switch_i(vcc_lt_switch_i), .store_en_o(store_en_o),
  .recall_start_o(recall_start_o), .busy_o(busy_o), .out_hiz_o(out_hiz_o),
  .req(req_q)
);

// File: tb/recall_supervisor_test.sv
module recall_supervisor_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lt_reset = 1'b1, lt_switch = 1'b1, store_req = 1'b0;
  logic store_en, start, busy, hiz, ready;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  recall_supervisor #(.RESTORE_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_lt_reset_i(lt_reset), .vcc_lt_switch_i(lt_switch),
    .store_req_i(store_req), .store_en_o(store_en), .recall_start_o(start),
    .busy_o(busy), .out_hiz_o(hiz), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic no_start(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      step();
      chk(start == 1'b0, req, int'(start), 0);
    end
  endtask

  task automatic measure_recall(input string req);
    int n;
    step();
    chk(start == 1'b1, "R2 start pulse", int'(start), 1);
    chk(hiz == 1'b1 && busy == 1'b1, "R3 busy with pulse", int'({busy, hiz}), 3);
    n = 0;
    while (busy && n < 100) begin
      n++;
      step();
      if (busy) chk(start == 1'b0, "R2 pulse one cycle", int'(start), 0);
    end
    chk(n == N, {req, " R3 busy length"}, n, N);
    chk(ready == 1'b1, "R4 ready after restore", int'(ready), 1);
  endtask

  task automatic t_reset();
    step();
    rst_n = 1'b1;
    step();
    chk(busy == 1'b0 && start == 1'b0, "R1 reset state", int'({busy, start}), 0);
    chk(ready == 1'b0, "R1 ready low", int'(ready), 0);
    no_start(4, "R1 no recall while low");
    lt_reset = 1'b0;
    no_start(3, "R6 wait for switch flag");
    lt_switch = 1'b0;
    measure_recall("R1 power-up");
  endtask

  task automatic t_shallow();
    lt_switch = 1'b1;
    #1 chk(ready == 1'b0, "R4 ready drops on dip", int'(ready), 0);
    no_start(4, "R5 shallow dip");
    lt_switch = 1'b0;
    #1 chk(ready == 1'b1, "R4 ready back", int'(ready), 1);
    no_start(5, "R5 no recall after shallow dip");
    chk(busy == 1'b0, "R5 no busy", int'(busy), 0);
  endtask

  task automatic t_deep_merge();
    lt_switch = 1'b1; lt_reset = 1'b1;
    step(); step();
    lt_reset = 1'b0;
    step();
    lt_reset = 1'b1;
    step();
    lt_reset = 1'b0;
    no_start(3, "R7 still low");
    lt_switch = 1'b0;
    measure_recall("R7 merged");
    no_start(6, "R7 single recall");
  endtask

  task automatic t_store();
    store_req = 1'b1;
    #1 chk(store_en == 1'b1, "R8 store passes", int'(store_en), 1);
    lt_switch = 1'b1;
    #1 chk(store_en == 1'b0, "R8 store blocked on dip", int'(store_en), 0);
    step();
    lt_switch = 1'b0;
    #1 chk(store_en == 1'b1, "R8 store restored", int'(store_en), 1);
    lt_switch = 1'b1; lt_reset = 1'b1;
    step();
    lt_switch = 1'b0; lt_reset = 1'b0;
    step();
    chk(busy == 1'b1 && store_en == 1'b0, "R8 store blocked while busy",
        int'(store_en), 0);
    while (busy) step();
    chk(store_en == 1'b1, "R8 store after restore", int'(store_en), 1);
    store_req = 1'b0;
    #1 chk(store_en == 1'b0, "R8 no request no enable", int'(store_en), 0);
  endtask

  task automatic t_invalid();
    store_req = 1'b1;
    lt_reset = 1'b1; lt_switch = 1'b0;
    #1 chk(store_en == 1'b0, "R9 invalid pair blocks store", int'(store_en), 0);
    chk(ready == 1'b0, "R9 ready low", int'(ready), 0);
    no_start(4, "R9 no recall while invalid");
    store_req = 1'b0;
    lt_reset = 1'b0;
    measure_recall("R9 recall after invalid");
  endtask

  initial begin
    t_reset();
    t_shallow();
    t_deep_merge();
    t_store();
    t_invalid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule